// File: doc/BRIEF.md
# GPIO Interrupt Cause Aggregator

This block turns the input pins of a 32-pin general-purpose I/O port into four upstream interrupt lines. Each pin is first XORed with a per-pin polarity bit, so that a polarity of 0 treats a high or rising pin as active and a polarity of 1 treats a low or falling pin as active. Two kinds of interrupt source come from the adjusted vector.

A level source follows the adjusted pin directly, with no storage. An edge source is captured in a sticky cause register on every 0-to-1 transition of the adjusted pin. Each kind is gated by its own mask register. The gated sources are ORed into a pending vector. Each group of eight consecutive pending bits drives one registered upstream line.

Software reaches the edge cause and the two mask registers through a simple write strobe with an address and a combinational read port. The two mask registers sit behind a parameterised address offset. An edge cause bit is cleared by writing 0 to its position.

Top module: `gpio_irq_agg`

## Requirements
- R1: The adjusted input of pin i is `pin_in[i] ^ pin_pol[i]`. With polarity 0, a high pin is active; with polarity 1, a low pin is active.
- R2: The level source of pin i is the adjusted input ANDed with bit i of the level mask. It is not latched, so it drops as soon as the adjusted input returns to 0.
- R3: A 0-to-1 transition of the adjusted input of pin i, detected against the value of the previous cycle, sets bit i of the edge cause register. That register reads back at address 0x14.
- R4: A set edge cause bit stays set while its adjusted input falls or stays low, until software clears it.
- R5: The pending vector is (level sources) OR (edge cause AND edge mask). `irq_out[g]` is the OR of pending bits 8g to 8g+7 and is registered, so it follows the pending vector one clock later.
- R6: A write to address 0x14 clears each edge cause bit whose write-data bit is 0. Bits whose write-data bit is 1 are left as they were.
- R7: If a new edge and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R8: After reset, the edge cause, the edge mask, the level mask and `irq_out` are all zero.
- R9: An edge cause bit whose edge mask bit is 0 is still latched and read back, but it does not raise `irq_out`.
- R10: The edge mask is at 0x18 + MASK_OFS and the level mask is at 0x1C + MASK_OFS; the default MASK_OFS is 0x20, giving 0x38 and 0x3C. Both registers take the full write data and read it back. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 32 | Sampled port pins |
| pin_pol | input | 32 | Per-pin polarity, 1 inverts the pin |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_out | output | 4 | Registered upstream interrupts, one per eight pins |

## Verification
The bench targets these corner cases:

- **Edge wins over a clearing write.** An edge and a clearing write land on the same bit in the same cycle. A design that gave the write priority would silently lose that interrupt.
- **Clear by writing 0.** A clear writes 1s to neighbouring set bits. A design that cleared on 1, or cleared the whole register, would either leave the target bit set or drop unrelated causes.
- **Level versus edge storage.** A level source must fall when the pin does, while an edge cause must survive the falling pin. Swapping the two storage rules shows up as a line that sticks or one that vanishes.
- **Group boundaries and latency.** Pins 23 and 24 are exercised to check the group edges, and the one-cycle output latency is checked, so that misrouted groups or a missing or extra register stage are caught.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PIN_COUNT    = 32;
  localparam int PINS_PER_IRQ = 8;
  localparam int BUS_AW       = 8;
  localparam int OFS_CAUSE    = 'h14;
  localparam int OFS_EMASK    = 'h18;
  localparam int OFS_LMASK    = 'h1C;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_EMASK = 2'd2,
    SEL_LMASK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = PIN_COUNT,
  parameter int ADDR_W   = BUS_AW,
  parameter int MASK_OFS = 'h20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NUM_PINS-1:0] reg_wdata,
  input  logic [NUM_PINS-1:0] cause_rd,
  output logic                cause_wr,
  output logic [NUM_PINS-1:0] edge_mask,
  output logic [NUM_PINS-1:0] level_mask,
  output logic [NUM_PINS-1:0] reg_rdata
);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(OFS_EMASK + MASK_OFS);
  localparam logic [ADDR_W-1:0] A_LMASK = ADDR_W'(OFS_LMASK + MASK_OFS);

  reg_sel_e sel;

  always_comb begin
    if (reg_addr == A_CAUSE)      sel = SEL_CAUSE;
    else if (reg_addr == A_EMASK) sel = SEL_EMASK;
    else if (reg_addr == A_LMASK) sel = SEL_LMASK;
    else                          sel = SEL_NONE;
  end

  assign cause_wr = reg_wr && (sel == SEL_CAUSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_mask  <= '0;
      level_mask <= '0;
    end else if (reg_wr) begin
      if (sel == SEL_EMASK) edge_mask  <= reg_wdata;
      if (sel == SEL_LMASK) level_mask <= reg_wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_CAUSE: reg_rdata = cause_rd;
      SEL_EMASK: reg_rdata = edge_mask;
      SEL_LMASK: reg_rdata = level_mask;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] adj_in,
  input  logic                cause_wr,
  input  logic [NUM_PINS-1:0] keep_bits,
  output logic [NUM_PINS-1:0] rise_vec,
  output logic [NUM_PINS-1:0] edge_cause
);
  logic [NUM_PINS-1:0] adj_q;
  logic [NUM_PINS-1:0] cause_next;

  assign rise_vec = adj_in & ~adj_q;

  // A fresh edge is ORed in after the clear, so it survives a same-cycle write.
  always_comb begin
    cause_next = cause_wr ? (edge_cause & keep_bits) : edge_cause;
    cause_next = cause_next | rise_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adj_q      <= '0;
      edge_cause <= '0;
    end else begin
      adj_q      <= adj_in;
      edge_cause <= cause_next;
    end
  end
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GRP   = NUM_PINS / GROUP_SIZE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pending,
  output logic [NUM_GRP-1:0]  irq_out
);
  logic [NUM_GRP-1:0] grp_or;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_or[g] = |pending[g*GROUP_SIZE +: GROUP_SIZE];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= grp_or;
  end
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = PIN_COUNT,
  parameter int GROUP_SIZE = PINS_PER_IRQ,
  parameter int ADDR_W     = BUS_AW,
  parameter int MASK_OFS   = 'h20,
  localparam int NUM_GRP   = NUM_PINS / GROUP_SIZE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] pin_pol,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NUM_PINS-1:0] reg_wdata,
  output logic [NUM_PINS-1:0] reg_rdata,
  output logic [NUM_GRP-1:0]  irq_out
);
  logic [NUM_PINS-1:0] adj;
  logic [NUM_PINS-1:0] rise_vec;
  logic [NUM_PINS-1:0] edge_cause;
  logic [NUM_PINS-1:0] edge_mask;
  logic [NUM_PINS-1:0] level_mask;
  logic [NUM_PINS-1:0] pending;
  logic                cause_wr;

  assign adj     = pin_in ^ pin_pol;
  assign pending = (adj & level_mask) | (edge_cause & edge_mask);

  gpio_irq_regs #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cause_rd(edge_cause), .cause_wr(cause_wr),
    .edge_mask(edge_mask), .level_mask(level_mask), .reg_rdata(reg_rdata)
  );

  gpio_edge_latch #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .adj_in(adj), .cause_wr(cause_wr),
    .keep_bits(reg_wdata), .rise_vec(rise_vec), .edge_cause(edge_cause)
  );

  gpio_irq_group #(.NUM_PINS(NUM_PINS), .GROUP_SIZE(GROUP_SIZE)) u_grp (
    .clk(clk), .rst_n(rst_n), .pending(pending), .irq_out(irq_out)
  );
endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int NUM_GRP  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [NUM_PINS-1:0] reg_wdata,
  input logic [NUM_PINS-1:0] rise_vec,
  input logic [NUM_PINS-1:0] edge_cause,
  input logic [NUM_PINS-1:0] pending,
  input logic [NUM_GRP-1:0]  irq_out
);
  logic cwr;
  assign cwr = reg_wr && (reg_addr == ADDR_W'('h14));

  assert_edge_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_vec != '0) |=> ((edge_cause & $past(rise_vec)) == $past(rise_vec)));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cwr |=> ((edge_cause & $past(edge_cause)) == $past(edge_cause)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr && rise_vec == '0) |=> (edge_cause == ($past(edge_cause) & $past(reg_wdata))));

  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr && rise_vec != '0) |=> ((edge_cause & $past(rise_vec)) == $past(rise_vec)));

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> ($past(pending) != '0));

  assert_irq_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |=> (irq_out != '0));
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .NUM_GRP(NUM_GRP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .rise_vec(rise_vec), .edge_cause(edge_cause),
  .pending(pending), .irq_out(irq_out)
);

// File: tb/gpio_irq_agg_bench.sv
module gpio_irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CAUSE = 8'h14;
  localparam logic [7:0] A_EMASK = 8'h38;
  localparam logic [7:0] A_LMASK = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_pol = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_agg u_gpio_irq_agg (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_pol(pin_pol),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CAUSE, v); check("R8 cause", v, 32'h0);
    rd(A_EMASK, v); check("R8 emask", v, 32'h0);
    rd(A_LMASK, v); check("R8 lmask", v, 32'h0);
    check("R8 irq", {28'h0, irq_out}, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(A_EMASK, 32'hA5A5_0F0F); wr(A_LMASK, 32'h1234_5678);
    rd(A_EMASK, v); check("R10 emask readback", v, 32'hA5A5_0F0F);
    rd(A_LMASK, v); check("R10 lmask readback", v, 32'h1234_5678);
    rd(8'h18, v);   check("R10 unmapped 0x18", v, 32'h0);
    wr(A_EMASK, 32'h0); wr(A_LMASK, 32'h0);
  endtask

  task automatic t_level;
    wr(A_LMASK, 32'h0002_0008);
    check("R2 idle", {28'h0, irq_out}, 32'h0);
    pin_in[3] = 1'b1; step(1);
    check("R2 R1 high level", {28'h0, irq_out}, 32'h1);
    pin_in[3] = 1'b0; step(1);
    check("R2 unlatched drop", {28'h0, irq_out}, 32'h0);
    pin_pol[17] = 1'b1; step(1);
    check("R1 low-active level", {28'h0, irq_out}, 32'h4);
    pin_in[17] = 1'b1; step(1);
    check("R1 low-active idle", {28'h0, irq_out}, 32'h0);
    wr(A_LMASK, 32'h0);
    pin_pol[17] = 1'b0; pin_in[17] = 1'b0; step(1);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(A_CAUSE, 32'h0);
    wr(A_EMASK, 32'h0200_0200);
    pin_in[9] = 1'b1; pin_in[25] = 1'b1; step(1);
    rd(A_CAUSE, v); check("R3 cause latched", v, 32'h0200_0200);
    check("R5 one-cycle latency", {28'h0, irq_out}, 32'h0);
    step(1);
    check("R5 irq after edge", {28'h0, irq_out}, 32'hA);
    pin_in[9] = 1'b0; pin_in[25] = 1'b0; step(2);
    rd(A_CAUSE, v); check("R4 sticky after fall", v, 32'h0200_0200);
    check("R4 irq held", {28'h0, irq_out}, 32'hA);
    wr(A_CAUSE, 32'hFFFF_FDFF);
    rd(A_CAUSE, v); check("R6 clear by zero", v, 32'h0200_0000);
    step(1);
    check("R6 irq after clear", {28'h0, irq_out}, 32'h8);
    wr(A_CAUSE, 32'h0); step(1);
    check("R6 all cleared", {28'h0, irq_out}, 32'h0);
  endtask

  task automatic t_unmasked;
    logic [31:0] v;
    wr(A_EMASK, 32'h0);
    pin_in[30] = 1'b1; step(2);
    rd(A_CAUSE, v); check("R9 masked still latched", v, 32'h4000_0000);
    check("R9 masked no irq", {28'h0, irq_out}, 32'h0);
    pin_in[30] = 1'b0; wr(A_CAUSE, 32'h0);
  endtask

  task automatic t_race;
    logic [31:0] v;
    pin_in[5] = 1'b1; step(1);
    pin_in[5] = 1'b0; step(1);
    rd(A_CAUSE, v); check("R7 setup", v, 32'h20);
    pin_in[5] = 1'b1;
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, v); check("R7 edge wins over clear", v, 32'h20);
    pin_in[5] = 1'b0; wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, v); check("R7 later clear works", v, 32'h0);
  endtask

  task automatic t_groups;
    wr(A_LMASK, 32'h8180_0000);
    pin_in[23] = 1'b1; step(1);
    check("R5 pin23 group2", {28'h0, irq_out}, 32'h4);
    pin_in[23] = 1'b0; pin_in[24] = 1'b1; step(1);
    check("R5 pin24 group3", {28'h0, irq_out}, 32'h8);
    pin_in[24] = 1'b0; pin_in[31] = 1'b1; step(1);
    check("R5 pin31 group3", {28'h0, irq_out}, 32'h8);
    pin_in[31] = 1'b0; wr(A_LMASK, 32'h0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_map();
    t_level();
    t_edge();
    t_unmasked();
    t_race();
    t_groups();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule